// File: doc/BRIEF.md
# Vectored Interrupt Priority Controller

This block sits in front of a small 8-bit processor core. It collects five external interrupt requests: a non-maskable trap, three maskable restart requests of rank 5.5, 6.5 and 7.5, and one general request that carries no vector of its own. Each input is captured according to its own trigger rule. The rank 7.5 input latches a rising edge. Ranks 6.5 and 5.5 follow the input level. The trap needs a rising edge and a high level. The controller then applies per-source mask bits and a global enable flag, and at each instruction boundary it picks the most urgent request.

When a vectored source wins, the controller pulses `takenOut` one cycle later and presents a fixed 16-bit vector equal to the source rank times eight. When the general request wins, the controller raises an acknowledge strobe for one cycle. It captures the restart opcode that the external device places on the data bus during that strobe and derives the vector from the opcode's restart index. Software changes the masks through a mask-write byte, which can also discard a pending rank 7.5 edge. Software reads a status byte that reports the masks, the enable flag and the pending requests.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset `takenOut` and `ackOut` are 0, all three mask bits are set, the global enable is clear and `statusOut` reads 0x07.
- R2: The fixed vectors are 0x0024 for the trap, 0x002C for rank 5.5, 0x0034 for rank 6.5 and 0x003C for rank 7.5, each reported with `fromOpcode` = 0.
- R3: When several requests are eligible at once, the choice follows this order: trap first, then 7.5, then 6.5, then 5.5, and the general request last.
- R4: A rising edge on `rq75In` sets a pending latch that stays set after the input falls, until the latch is cleared.
- R5: `rq65In` and `rq55In` are level sensitive. A level that falls before the boundary leaves nothing behind.
- R6: The trap fires only while `trapIn` is high and after a rising edge has been seen. Holding it high after it is taken does not fire it again, and a pulse that ends before the boundary does not fire.
- R7: `enCmd` sets the global enable and `disCmd` clears it. Acceptance of any interrupt clears it, and acceptance wins over an `enCmd` in the same cycle. While the enable is clear, every maskable source is ignored and the trap is not.
- R8: Requests are considered only in a cycle where `boundary` is 1. `takenOut` for a vectored source rises in the following cycle.
- R9: For the general request, `ackOut` is 1 for exactly the cycle after acceptance. The opcode on `busData` in that cycle yields the vector (bits 5:3) × 8, with `fromOpcode` = 1 and `takenOut` one cycle later (for example 0xC7→0x0000, 0xEF→0x0028, 0xFF→0x0038).
- R10: In a mask write, bit 3 must be 1 for bits 2:0 (mask 5.5, 6.5, 7.5; 1 = masked) to load. Bit 4 clears the 7.5 latch whatever bit 3 holds. A new 7.5 edge in the same cycle wins over the clear.
- R11: `statusOut` holds the masks in bits 2:0 and the enable in bit 3. Bits 4, 5 and 6 hold the pending 5.5 level, 6.5 level and 7.5 latch, and bit 7 is 0.
- R12: Acceptance of rank 7.5 clears its pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapIn | input | 1 | Non-maskable trap request |
| rq75In | input | 1 | Rank 7.5 request, rising-edge latched |
| rq65In | input | 1 | Rank 6.5 request, level |
| rq55In | input | 1 | Rank 5.5 request, level |
| extReqIn | input | 1 | General request without a fixed vector |
| boundary | input | 1 | Core is at an instruction boundary |
| enCmd | input | 1 | Set global enable |
| disCmd | input | 1 | Clear global enable |
| maskWr | input | 1 | Mask-write strobe |
| maskData | input | 8 | Mask-write byte |
| busData | input | 8 | Restart opcode from the external device |
| statusOut | output | 8 | Status byte |
| ackOut | output | 1 | Acknowledge strobe for the general request |
| takenOut | output | 1 | One-cycle interrupt-taken pulse |
| vectorOut | output | 16 | Vector address for the core |
| fromOpcode | output | 1 | 1 when the vector came from the captured opcode |

## Verification
Two pairs of functions can hit the same cycle. The first pair is a fresh rising edge on the 7.5 input and a mask write that clears its latch. The bench drives both at the same falling edge and then reads the status byte, where the latch must still show pending. The second pair is an accepted interrupt and an enable command. The bench raises `enCmd` together with `boundary` while rank 5.5 is eligible. The vector must appear on the scoreboard and the status enable bit must read 0 afterwards.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Source identifiers; value - 1 is the bit index in the request vector,
  // which is also the priority order (lower index wins).
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_TRAP = 3'd1,
    SRC_R75  = 3'd2,
    SRC_R65  = 3'd3,
    SRC_R55  = 3'd4,
    SRC_EXT  = 3'd5
  } srcT;

  // Strobes from control to datapath
  typedef struct packed {
    logic take;    // accept a request this cycle
    srcT  src;     // which source was accepted
    logic grabOp;  // capture restart opcode from the bus this cycle
  } strobeT;

  localparam int REQ_TRAP = 0;
  localparam int REQ_R75  = 1;
  localparam int REQ_R65  = 2;
  localparam int REQ_R55  = 3;
  localparam int REQ_EXT  = 4;

  // Twice the rank of each fixed source (rank 4.5, 7.5, 6.5, 5.5)
  function automatic int halfRank(srcT s);
    case (s)
      SRC_TRAP: return 9;
      SRC_R75:  return 15;
      SRC_R65:  return 13;
      SRC_R55:  return 11;
      default:  return 0;
    endcase
  endfunction

endpackage

// File: rtl/irq_control.sv
module irq_control
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               boundary,
  input  logic [NUM_SRC-1:0] reqVec,
  output strobeT             strobes,
  output logic               ackOut
);

  typedef enum logic {ST_IDLE, ST_ACK} stateT;
  stateT state;
  srcT   pick;

  // Lowest set index is the most urgent
  always_comb begin
    pick = SRC_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (reqVec[i]) pick = srcT'(3'(i + 1));
    end
  end

  always_comb begin
    strobes.take   = (state == ST_IDLE) && boundary && (pick != SRC_NONE);
    strobes.src    = pick;
    strobes.grabOp = (state == ST_ACK);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (strobes.take && pick == SRC_EXT) state <= ST_ACK;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign ackOut = (state == ST_ACK);

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);  // R9

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int OP_W    = 8,
  parameter int VEC_W   = 16,
  parameter int MASK_N  = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               trapIn,
  input  logic               rq75In,
  input  logic               rq65In,
  input  logic               rq55In,
  input  logic               extReqIn,
  input  logic               enCmd,
  input  logic               disCmd,
  input  logic               maskWr,
  input  logic [OP_W-1:0]    maskData,
  input  logic [OP_W-1:0]    busData,
  input  strobeT             strobes,
  output logic [NUM_SRC-1:0] reqVec,
  output logic [OP_W-1:0]    statusOut,
  output logic               takenOut,
  output logic [VEC_W-1:0]   vectorOut,
  output logic               fromOpcode
);

  localparam int MW_SETEN = MASK_N;       // mask-set-enable bit
  localparam int MW_CLR75 = MASK_N + 1;   // clear 7.5 latch bit
  localparam int IDX_LO   = 3;            // restart index field in opcode
  localparam int IDX_W    = 3;
  localparam int PAD_W    = VEC_W - IDX_W - IDX_LO;

  logic              trapPrev, r75Prev, trapEdge, pend75, enFlag;
  logic [MASK_N-1:0] maskQ;
  logic              acceptTrap, accept75, rise75, riseTrap;
  logic              unusedBits;

  assign acceptTrap = strobes.take && strobes.src == SRC_TRAP;
  assign accept75   = strobes.take && strobes.src == SRC_R75;
  assign rise75     = rq75In && !r75Prev;
  assign riseTrap   = trapIn && !trapPrev;
  assign unusedBits = ^{maskData[OP_W-1:MW_CLR75+1], busData[OP_W-1:IDX_LO+IDX_W],
                        busData[IDX_LO-1:0]};

  // Trigger capture, masks and enable
  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapPrev <= 1'b0;
      r75Prev  <= 1'b0;
      trapEdge <= 1'b0;
      pend75   <= 1'b0;
      enFlag   <= 1'b0;
      maskQ    <= '1;
    end else begin
      trapPrev <= trapIn;
      r75Prev  <= rq75In;
      if (rise75)                                      pend75 <= 1'b1;
      else if (accept75 || (maskWr && maskData[MW_CLR75])) pend75 <= 1'b0;
      if (riseTrap)        trapEdge <= 1'b1;
      else if (acceptTrap) trapEdge <= 1'b0;
      if (strobes.take)    enFlag <= 1'b0;
      else if (enCmd)      enFlag <= 1'b1;
      else if (disCmd)     enFlag <= 1'b0;
      if (maskWr && maskData[MW_SETEN]) maskQ <= maskData[MASK_N-1:0];
    end
  end

  // Eligible requests in priority order
  always_comb begin
    reqVec          = '0;
    reqVec[REQ_TRAP] = trapEdge && trapIn;
    reqVec[REQ_R75]  = enFlag && !maskQ[2] && pend75;
    reqVec[REQ_R65]  = enFlag && !maskQ[1] && rq65In;
    reqVec[REQ_R55]  = enFlag && !maskQ[0] && rq55In;
    reqVec[REQ_EXT]  = enFlag && extReqIn;
  end

  always_comb begin
    statusOut = '0;
    statusOut[MASK_N-1:0] = maskQ;
    statusOut[MASK_N]     = enFlag;
    statusOut[MASK_N+1]   = rq55In;
    statusOut[MASK_N+2]   = rq65In;
    statusOut[MASK_N+3]   = pend75;
  end

  // Vector output register
  always_ff @(posedge clk) begin
    if (!rstN) begin
      takenOut   <= 1'b0;
      vectorOut  <= '0;
      fromOpcode <= 1'b0;
    end else begin
      takenOut <= 1'b0;
      if (strobes.take && strobes.src != SRC_EXT) begin
        takenOut   <= 1'b1;
        vectorOut  <= VEC_W'(halfRank(strobes.src) * 4);
        fromOpcode <= 1'b0;
      end else if (strobes.grabOp) begin
        takenOut   <= 1'b1;
        vectorOut  <= {{PAD_W{1'b0}}, busData[IDX_LO+IDX_W-1:IDX_LO], {IDX_LO{1'b0}}};
        fromOpcode <= 1'b1;
      end
    end
  end

  AST_TAKE_DROPS_EN: assert property (@(posedge clk) disable iff (!rstN)
    strobes.take |=> !enFlag);  // R7

  AST_PEND75_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    pend75 && !maskWr && !accept75 |=> pend75);  // R4

  AST_MASK_GATED: assert property (@(posedge clk) disable iff (!rstN)
    maskWr && !maskData[MW_SETEN] |=> $stable(maskQ));  // R10

  AST_PEND75_TAKEN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    accept75 && !rise75 |=> !pend75);  // R12

endmodule

// File: rtl/irq_vector_ctrl.sv
module irq_vector_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 5,
  parameter int OP_W    = 8,
  parameter int VEC_W   = 16,
  parameter int MASK_N  = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trapIn,
  input  logic             rq75In,
  input  logic             rq65In,
  input  logic             rq55In,
  input  logic             extReqIn,
  input  logic             boundary,
  input  logic             enCmd,
  input  logic             disCmd,
  input  logic             maskWr,
  input  logic [OP_W-1:0]  maskData,
  input  logic [OP_W-1:0]  busData,
  output logic [OP_W-1:0]  statusOut,
  output logic             ackOut,
  output logic             takenOut,
  output logic [VEC_W-1:0] vectorOut,
  output logic             fromOpcode
);

  strobeT             strobes;
  logic [NUM_SRC-1:0] reqVec;

  irq_control #(.NUM_SRC(NUM_SRC)) u_control (
    .clk(clk), .rstN(rstN), .boundary(boundary), .reqVec(reqVec),
    .strobes(strobes), .ackOut(ackOut)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .OP_W(OP_W), .VEC_W(VEC_W), .MASK_N(MASK_N)) u_datapath (
    .clk(clk), .rstN(rstN), .trapIn(trapIn), .rq75In(rq75In), .rq65In(rq65In),
    .rq55In(rq55In), .extReqIn(extReqIn), .enCmd(enCmd), .disCmd(disCmd),
    .maskWr(maskWr), .maskData(maskData), .busData(busData), .strobes(strobes),
    .reqVec(reqVec), .statusOut(statusOut), .takenOut(takenOut),
    .vectorOut(vectorOut), .fromOpcode(fromOpcode)
  );

  AST_TAKE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rstN)
    takenOut && !fromOpcode |-> $past(boundary));  // R8

  AST_TRAP_LEVEL: assert property (@(posedge clk) disable iff (!rstN)
    takenOut && !fromOpcode && vectorOut == VEC_W'(36) |-> $past(trapIn));  // R6

  AST_ACK_NO_TAKE: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |-> !takenOut);  // R9

endmodule

// File: tb/irq_vector_ctrl_bench.sv
module irq_vector_ctrl_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapIn = 0, rq75In = 0, rq65In = 0, rq55In = 0, extReqIn = 0;
  logic        boundary = 0, enCmd = 0, disCmd = 0, maskWr = 0;
  logic [7:0]  maskData = 0, busData = 0;
  logic [7:0]  statusOut;
  logic        ackOut, takenOut, fromOpcode;
  logic [15:0] vectorOut;

  int nChecks = 0;
  int nFail = 0;
  logic [15:0] vecQ[$];
  logic        opQ[$];
  string       tagQ[$];

  always #2.5 clk = ~clk;  // 200 MHz

  irq_vector_ctrl u_irq_vector_ctrl (
    .clk(clk), .rstN(rstN), .trapIn(trapIn), .rq75In(rq75In), .rq65In(rq65In),
    .rq55In(rq55In), .extReqIn(extReqIn), .boundary(boundary), .enCmd(enCmd),
    .disCmd(disCmd), .maskWr(maskWr), .maskData(maskData), .busData(busData),
    .statusOut(statusOut), .ackOut(ackOut), .takenOut(takenOut),
    .vectorOut(vectorOut), .fromOpcode(fromOpcode)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chkStatus(input string tag, input logic [7:0] exp);
    #1 chk(tag, {8'h00, statusOut}, {8'h00, exp});
  endtask

  task automatic expectVec(input logic [15:0] v, input logic op, input string tag);
    vecQ.push_back(v);
    opQ.push_back(op);
    tagQ.push_back(tag);
  endtask

  // Monitor: compares every taken pulse against the scoreboard
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rstN && takenOut) begin
        if (vecQ.size() == 0) begin
          chk("unexpected take R8", vectorOut, 16'hFFFF);
        end else begin
          string t;
          t = tagQ.pop_front();
          chk(t, vectorOut, vecQ.pop_front());
          chk({t, " source flag"}, {15'd0, fromOpcode}, {15'd0, opQ.pop_front()});
        end
      end
    end
  end

  task automatic doBoundary(output logic t);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    #1 t = takenOut;
  endtask

  task automatic noTake(input string tag);
    logic t;
    doBoundary(t);
    chk(tag, {15'd0, t}, 16'd0);
  endtask

  task automatic takeVec(input logic [15:0] v, input string tag);
    logic t;
    expectVec(v, 1'b0, tag);
    doBoundary(t);
    chk({tag, " pulse"}, {15'd0, t}, 16'd1);
  endtask

  task automatic pulseEn;
    @(negedge clk); enCmd = 1;
    @(negedge clk); enCmd = 0;
  endtask

  task automatic maskWrite(input logic [7:0] d);
    @(negedge clk); maskWr = 1; maskData = d;
    @(negedge clk); maskWr = 0;
  endtask

  task automatic pulse75;
    @(negedge clk); rq75In = 1;
    @(negedge clk); rq75In = 0;
  endtask

  task automatic extAccept(input logic [7:0] op, input logic [15:0] v, input string tag);
    expectVec(v, 1'b1, tag);
    @(negedge clk); boundary = 1;
    @(negedge clk); boundary = 0;
    #1 chk({tag, " ack high"}, {15'd0, ackOut}, 16'd1);
    busData = op;
    @(negedge clk);
    #1 chk({tag, " ack low"}, {15'd0, ackOut}, 16'd0);
    chk({tag, " pulse"}, {15'd0, takenOut}, 16'd1);
    busData = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    logic t;
    repeat (4) @(negedge clk);
    rstN = 1;
    // R1 reset state
    #1 chk("R1 taken after reset", {15'd0, takenOut}, 16'd0);
    chk("R1 ack after reset", {15'd0, ackOut}, 16'd0);
    chk("R1 R11 status after reset", {8'h00, statusOut}, 16'h0007);

    // R8 nothing pending: no take
    noTake("R8 idle boundary");
    // R6 R7 R2 trap fires without enable
    @(negedge clk); trapIn = 1;
    takeVec(16'h0024, "R2 R7 trap vector");
    noTake("R6 trap held high");
    @(negedge clk); trapIn = 0;
    // R6 short pulse ending before boundary
    @(negedge clk); trapIn = 1;
    @(negedge clk); trapIn = 0;
    noTake("R6 trap pulse gone");

    // R7 enable, R10 masks block 5.5
    pulseEn;
    chkStatus("R7 R11 enable set", 8'h0F);
    rq55In = 1;
    chkStatus("R11 pending 5.5", 8'h1F);
    noTake("R10 masked 5.5");
    maskWrite(8'h00);
    chkStatus("R10 mask write without set-enable", 8'h1F);
    maskWrite(8'h08);
    chkStatus("R10 masks cleared", 8'h18);

    // R8 only at boundary
    repeat (3) @(negedge clk);
    #1 chk("R8 no take without boundary", {15'd0, takenOut}, 16'd0);
    takeVec(16'h002C, "R2 5.5 vector");
    chkStatus("R7 enable cleared by acceptance", 8'h10);
    noTake("R7 disabled 5.5 ignored");
    rq55In = 0;

    // R5 level source that dropped
    pulseEn;
    @(negedge clk); rq65In = 1;
    @(negedge clk); rq65In = 0;
    noTake("R5 dropped 6.5 level");
    chkStatus("R5 nothing pending", 8'h08);

    // R4 R12 7.5 edge latch
    pulse75;
    chkStatus("R4 7.5 latched after input fell", 8'h48);
    takeVec(16'h003C, "R2 7.5 vector");
    chkStatus("R12 7.5 latch cleared on acceptance", 8'h00);

    // R3 priority order
    pulseEn;
    @(negedge clk); rq55In = 1; rq65In = 1; extReqIn = 1; trapIn = 1; rq75In = 1;
    @(negedge clk); rq75In = 0;
    takeVec(16'h0024, "R3 trap first");
    pulseEn; takeVec(16'h003C, "R3 7.5 second");
    pulseEn; takeVec(16'h0034, "R3 6.5 third");
    rq65In = 0;
    pulseEn; takeVec(16'h002C, "R3 5.5 fourth");
    rq55In = 0; trapIn = 0;
    // R9 general request handshake
    pulseEn; extAccept(8'hC7, 16'h0000, "R3 R9 general request last");
    chkStatus("R9 enable cleared", 8'h00);
    pulseEn; extAccept(8'hEF, 16'h0028, "R9 opcode EF");
    pulseEn; extAccept(8'hFF, 16'h0038, "R9 opcode FF");
    extReqIn = 0;

    // R7 acceptance beats enable command in the same cycle
    pulseEn;
    expectVec(16'h002C, 1'b0, "R7 take with enable command");
    @(negedge clk); rq55In = 1; enCmd = 1; boundary = 1;
    @(negedge clk); enCmd = 0; boundary = 0;
    chkStatus("R7 acceptance wins over enable", 8'h10);
    rq55In = 0;

    // R10 latch clear and same-cycle edge
    pulse75;
    chkStatus("R4 7.5 pending", 8'h40);
    maskWrite(8'h10);
    chkStatus("R10 clear of 7.5 latch", 8'h00);
    @(negedge clk); rq75In = 1; maskWr = 1; maskData = 8'h10;
    @(negedge clk); maskWr = 0;
    chkStatus("R10 new edge wins over clear", 8'h40);
    rq75In = 0;
    maskWrite(8'h0C);
    chkStatus("R10 7.5 masked", 8'h44);
    pulseEn;
    noTake("R10 masked 7.5 not taken");
    maskWrite(8'h08);
    chkStatus("R10 7.5 unmasked", 8'h48);
    takeVec(16'h003C, "R10 7.5 after unmask");
    chkStatus("R12 latch clear", 8'h00);

    // R7 disable command
    pulseEn;
    chkStatus("R7 enable", 8'h08);
    @(negedge clk); disCmd = 1;
    @(negedge clk); disCmd = 0;
    chkStatus("R7 disable command", 8'h00);

    repeat (3) @(negedge clk);
    chk("R8 scoreboard drained", 16'(vecQ.size()), 16'd0);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

endmodule